// File: doc/BRIEF.md
# Group Run Encoder

This block compresses one 64-column slice of a pixel row into a short list of run records. Each column group of a row is handed to it as a bit vector of threshold hits together with the group number. The block looks for runs of adjacent set pixels, lowest column first. It writes each run as an 8-bit record holding the column where the run begins and its length. Runs longer than four pixels are cut into pieces of at most four. At most six records are kept per group and row, and anything beyond that is discarded.

A scan begins with a one-cycle `row_valid` strobe while the block is idle. An internal controller then walks the hit mask. It finds one run per cycle with a lowest-set-bit search and clears that run from the mask. When the mask is empty or all six record slots are filled, the block raises `done` for one cycle. The record slots, their valid flags, the record count and the captured group number stay on the outputs until the next row is accepted. The longest scan is well inside a 16-cycle row period.

The controller has three named states:
- `ST_IDLE`: waits for a row.
- `ST_SCAN`: emits one record per cycle.
- `ST_DONE`: presents the result.

It has four named transitions:
- T_START: `ST_IDLE` to `ST_SCAN` on `row_valid`.
- T_EMIT: `ST_SCAN` stays in `ST_SCAN` while a run remains and a slot is free.
- T_FINISH: `ST_SCAN` to `ST_DONE` when the mask is empty or the slots are full.
- T_RETIRE: `ST_DONE` to `ST_IDLE` unconditionally.

Top module: `grp_run_encoder`

## Requirements
- R1: When `row_valid` is high in `ST_IDLE`, the block captures `row_bits` and `group_id`, and `bank_addr` then shows that `group_id`.
- R2: Each maximal run of set bits in `row_bits` (bit i is column i) becomes a record. Record bits [7:2] hold the column of the run's first pixel, and bits [1:0] hold the run length minus one (0 means 1 pixel, 3 means 4 pixels).
- R3: A run longer than 4 pixels is split. The first 4 pixels form one record with code 3, and encoding continues with a new record at that column plus 4.
- R4: Records occupy slots in ascending column order. Slot 0 (`state_words[7:0]`) holds the lowest column, and slot i sits at `state_words[8*i+7:8*i]`.
- R5: At most 6 records are produced per row. Runs beyond the sixth are dropped, and `state_count` is then 6.
- R6: `state_count` equals the number of records. `state_valid[i]` is 1 exactly for slots i below `state_count`.
- R7: A row with no set bit gives `state_count` 0, `state_valid` all 0 and `state_words` all 0. The same holds for every unused slot in other rows, where the words read 0.
- R8: `done` is high for exactly one cycle, at most 7 cycles after the cycle following the `row_valid` strobe. All result outputs then hold their values until the next row is accepted.
- R9: A `row_valid` strobe that arrives while a scan is in progress is ignored, and the result reflects the row already captured.
- R10: During and right after reset, `done`, `state_count`, `state_valid`, `state_words` and `bank_addr` are all 0.
- R11: A run that reaches column 63 ends there and does not wrap to column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_valid | input | 1 | One-cycle strobe: start encoding `row_bits` |
| row_bits | input | 64 | Hit mask of the group, bit i = column i |
| group_id | input | 5 | Group (bank) number of this slice |
| done | output | 1 | One-cycle pulse: result is ready |
| state_count | output | 3 | Number of valid records |
| state_valid | output | 6 | Per-slot valid flags |
| state_words | output | 48 | Six 8-bit records, slot 0 in the low byte |
| bank_addr | output | 5 | Group number captured with the row |

## Verification
The bench builds the block with its default parameters: 64 columns, runs capped at 4 pixels, 6 slots and a 5-bit group number. These values make the interesting boundaries reachable with modest stimulus. A full mask saturates all six slots with 4-pixel records, seven isolated hits overflow the slot limit by one, and a run of nine pixels shows a three-way split. Runs placed at columns 62 and 63 exercise the end of the group. Seeded random masks of sparse, medium and dense fill are compared against a bench-side column walk, which checks ordering, splitting and truncation together.

// File: rtl/grp_run_pkg.sv
package grp_run_pkg;

    // Scan controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_DONE = 2'd2
    } scan_state_e;

endpackage

// File: rtl/grp_run_finder.sv
// Combinational search: lowest set bit of the mask, length of the run
// starting there (capped), and the mask with that run removed.
module grp_run_finder #(
    parameter int GROUP_W = 64,
    parameter int RUN_MAX = 4,
    localparam int COL_W  = $clog2(GROUP_W),
    localparam int CODE_W = $clog2(RUN_MAX)
) (
    input  logic [GROUP_W-1:0] mask,
    output logic               found,
    output logic [COL_W-1:0]   pos,
    output logic [CODE_W-1:0]  code,
    output logic [GROUP_W-1:0] rest
);

    logic [GROUP_W-1:0] shifted;
    logic [COL_W+1:0]   cut;
    logic               stop;

    always_comb begin
        found = |mask;
        pos   = '0;
        for (int i = GROUP_W - 1; i >= 0; i--) begin
            if (mask[i]) begin
                pos = COL_W'(i);
            end
        end
    end

    // Zeros shifted in at the top end a run at the last column.
    assign shifted = mask >> pos;

    always_comb begin
        code = '0;
        stop = 1'b0;
        for (int k = 1; k < RUN_MAX; k++) begin
            if (!stop) begin
                if (shifted[k]) begin
                    code = CODE_W'(k);
                end else begin
                    stop = 1'b1;
                end
            end
        end
    end

    assign cut  = {2'b00, pos} + (COL_W+2)'(code) + (COL_W+2)'(1);
    assign rest = mask & ({GROUP_W{1'b1}} << cut);

endmodule

// File: rtl/grp_state_file.sv
// Record slots with valid flags; cleared at the start of each row.
module grp_state_file #(
    parameter int SLOTS  = 6,
    parameter int WORD_W = 8,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [WORD_W-1:0]       wr_word,
    output logic [SLOTS*WORD_W-1:0] words,
    output logic [SLOTS-1:0]        valid
);

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [WORD_W-1:0] word_q;
        logic              vld_q;

        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                word_q <= '0;
                vld_q  <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(s))) begin
                word_q <= wr_word;
                vld_q  <= 1'b1;
            end
        end

        assign words[s*WORD_W +: WORD_W] = word_q;
        assign valid[s]                  = vld_q;
    end

endmodule

// File: rtl/grp_run_encoder.sv
module grp_run_encoder
    import grp_run_pkg::*;
#(
    parameter int GROUP_W    = 64,
    parameter int RUN_MAX    = 4,
    parameter int MAX_STATES = 6,
    parameter int BANK_W     = 5,
    localparam int COL_W     = $clog2(GROUP_W),
    localparam int CODE_W    = $clog2(RUN_MAX),
    localparam int WORD_W    = COL_W + CODE_W,
    localparam int CNT_W     = $clog2(MAX_STATES + 1),
    localparam int IDX_W     = (MAX_STATES > 1) ? $clog2(MAX_STATES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         row_valid,
    input  logic [GROUP_W-1:0]           row_bits,
    input  logic [BANK_W-1:0]            group_id,
    output logic                         done,
    output logic [CNT_W-1:0]             state_count,
    output logic [MAX_STATES-1:0]        state_valid,
    output logic [MAX_STATES*WORD_W-1:0] state_words,
    output logic [BANK_W-1:0]            bank_addr
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(MAX_STATES);

    scan_state_e        state_q, state_d;
    logic [GROUP_W-1:0] mask_q;
    logic [BANK_W-1:0]  bank_q;
    logic [CNT_W-1:0]   cnt_q;

    logic               run_found;
    logic [COL_W-1:0]   run_pos;
    logic [CODE_W-1:0]  run_code;
    logic [GROUP_W-1:0] run_rest;

    logic start, emit;

    grp_run_finder #(
        .GROUP_W (GROUP_W),
        .RUN_MAX (RUN_MAX)
    ) u_finder (
        .mask  (mask_q),
        .found (run_found),
        .pos   (run_pos),
        .code  (run_code),
        .rest  (run_rest)
    );

    assign start = (state_q == ST_IDLE) && row_valid;
    assign emit  = (state_q == ST_SCAN) && run_found && (cnt_q != CNT_FULL);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: T_START, T_EMIT, T_FINISH, T_RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (row_valid) state_d = ST_SCAN;
            ST_SCAN: if (!emit)     state_d = ST_DONE;
            ST_DONE:                state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // Scan datapath: mask consumed one run per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            bank_q <= '0;
            cnt_q  <= '0;
        end else if (start) begin
            mask_q <= row_bits;
            bank_q <= group_id;
            cnt_q  <= '0;
        end else if (emit) begin
            mask_q <= run_rest;
            cnt_q  <= cnt_q + CNT_W'(1);
        end
    end

    grp_state_file #(
        .SLOTS  (MAX_STATES),
        .WORD_W (WORD_W)
    ) u_slots (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start),
        .wr_en   (emit),
        .wr_idx  (cnt_q[IDX_W-1:0]),
        .wr_word ({run_pos, run_code}),
        .words   (state_words),
        .valid   (state_valid)
    );

    // Outputs
    always_comb begin
        done        = (state_q == ST_DONE);
        state_count = cnt_q;
        bank_addr   = bank_q;
    end

endmodule

// File: rtl/grp_run_encoder_chk.sv
module grp_run_encoder_chk
    import grp_run_pkg::*;
#(
    parameter int GROUP_W    = 64,
    parameter int RUN_MAX    = 4,
    parameter int MAX_STATES = 6,
    parameter int BANK_W     = 5,
    localparam int COL_W     = $clog2(GROUP_W),
    localparam int CODE_W    = $clog2(RUN_MAX),
    localparam int WORD_W    = COL_W + CODE_W,
    localparam int CNT_W     = $clog2(MAX_STATES + 1)
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         row_valid,
    input scan_state_e                  state_q,
    input logic                         done,
    input logic [CNT_W-1:0]             state_count,
    input logic [MAX_STATES-1:0]        state_valid,
    input logic [MAX_STATES*WORD_W-1:0] state_words,
    input logic [BANK_W-1:0]            bank_addr
);

    logic [MAX_STATES:0] valid_plus;
    assign valid_plus = {1'b0, state_valid} + (MAX_STATES+1)'(1);

    assert_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && row_valid) |=> (state_q == ST_SCAN));

    assert_count_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state_count <= CNT_W'(MAX_STATES));

    assert_valid_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (($countones(state_valid) == int'(state_count)) &&
                  ((state_valid & valid_plus[MAX_STATES-1:0]) == '0)));

    assert_empty_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && state_count == '0) |-> (state_words == '0));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !row_valid) |=> ($stable(state_words) && $stable(state_valid)));

    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && row_valid) |=> $stable(bank_addr));

    for (genvar i = 1; i < MAX_STATES; i++) begin : g_order
        assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (done && state_valid[i]) |->
            (state_words[i*WORD_W+CODE_W +: COL_W] > state_words[(i-1)*WORD_W+CODE_W +: COL_W]));
    end

endmodule

bind grp_run_encoder grp_run_encoder_chk #(
    .GROUP_W    (GROUP_W),
    .RUN_MAX    (RUN_MAX),
    .MAX_STATES (MAX_STATES),
    .BANK_W     (BANK_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .row_valid   (row_valid),
    .state_q     (state_q),
    .done        (done),
    .state_count (state_count),
    .state_valid (state_valid),
    .state_words (state_words),
    .bank_addr   (bank_addr)
);

// File: tb/grp_run_encoder_tb.sv
`timescale 1ns/1ps
module grp_run_encoder_tb;

    localparam int GW = 64;
    localparam int MS = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          row_valid = 1'b0;
    logic [GW-1:0] row_bits = '0;
    logic [4:0]    group_id = '0;
    logic          done;
    logic [2:0]    state_count;
    logic [MS-1:0] state_valid;
    logic [MS*8-1:0] state_words;
    logic [4:0]    bank_addr;

    int errors = 0;
    int checks = 0;

    grp_run_encoder u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .row_valid   (row_valid),
        .row_bits    (row_bits),
        .group_id    (group_id),
        .done        (done),
        .state_count (state_count),
        .state_valid (state_valid),
        .state_words (state_words),
        .bank_addr   (bank_addr)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Column walk: runs capped at 4, at most MS records
    function automatic void model(input logic [GW-1:0] b,
                                  output logic [MS*8-1:0] w, output int n);
        int i;
        int len;
        int first;
        w = '0;
        n = 0;
        i = 0;
        while (i < GW && n < MS) begin
            if (b[i]) begin
                first = i;
                len = 0;
                while (i < GW && b[i] && len < 4) begin
                    len++;
                    i++;
                end
                w[n*8 +: 8] = {6'(first), 2'(len - 1)};
                n++;
            end else begin
                i++;
            end
        end
    endfunction

    task automatic run_row(input string tag, input logic [GW-1:0] b,
                           input logic [4:0] g, input bit intrude);
        logic [MS*8-1:0] ew;
        logic [MS*8-1:0] held;
        int en;
        int waited;
        model(b, ew, en);
        @(negedge clk);
        row_valid = 1'b1;
        row_bits  = b;
        group_id  = g;
        @(negedge clk);
        row_valid = 1'b0;
        waited = 0;
        if (intrude) begin
            row_valid = 1'b1;
            row_bits  = ~b;
            group_id  = ~g;
            @(negedge clk);
            row_valid = 1'b0;
            waited = 1;
        end
        while (!done && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        chk({tag, " R8 done seen"}, 64'(done), 64'd1);
        chk({tag, " R8 latency ok"}, 64'(waited <= MS + 1), 64'd1);
        chk({tag, " R6 count"}, 64'(state_count), 64'(en));
        chk({tag, " R6 valid"}, 64'(state_valid), 64'((1 << en) - 1));
        chk({tag, " words"}, 64'(state_words), 64'(ew));
        chk({tag, " R1 bank"}, 64'(bank_addr), 64'(g));
        held = state_words;
        @(negedge clk);
        chk({tag, " R8 pulse"}, 64'(done), 64'd0);
        @(negedge clk);
        chk({tag, " R8 held"}, 64'(state_words), 64'(held));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [GW-1:0] a, b, c, m;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R10 done in reset", 64'(done), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 done", 64'(done), 64'd0);
        chk("R10 count", 64'(state_count), 64'd0);
        chk("R10 valid", 64'(state_valid), 64'd0);
        chk("R10 words", 64'(state_words), 64'd0);
        chk("R10 bank", 64'(bank_addr), 64'd0);

        run_row("R7 empty", 64'd0, 5'd3, 1'b0);
        run_row("R2 single col5", 64'h20, 5'd0, 1'b0);
        run_row("R2 runs 2/3/4", 64'h0000_0F00_7003, 5'd14, 1'b0);
        run_row("R3 run of 6", 64'h3F << 10, 5'd7, 1'b0);
        run_row("R3 run of 9", 64'h1FF, 5'd1, 1'b0);
        run_row("R11 cols 62-63", 64'hC000_0000_0000_0000, 5'd9, 1'b0);
        run_row("R11 col 63 and 0", 64'h8000_0000_0000_0001, 5'd2, 1'b0);
        run_row("R5 seven singles", 64'h1555, 5'd5, 1'b0);
        run_row("R5 full mask", '1, 5'd11, 1'b0);
        run_row("R9 intrude", 64'h0F0F, 5'd4, 1'b1);
        run_row("R9 intrude empty", 64'd0, 5'd6, 1'b1);

        for (int r = 0; r < 60; r++) begin
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            c = {$urandom, $urandom};
            case (r % 3)
                0:       m = a & b & c;
                1:       m = a & b;
                default: m = a | b;
            endcase
            run_row("R4 random", m, 5'($urandom % 15), 1'b0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule